// File: doc/BRIEF.md
# RS-485 Line-Driver Direction Controller

This block decides the level of a UART's RTS and DTR pins when one of them steers the enable input of a half-duplex RS-485 line transceiver. In automatic direction mode, the chosen pin asserts the driver as soon as a character is queued in the transmit FIFO. It keeps the driver asserted while the shift register is busy. When both are idle, it holds the driver on for a programmed number of bit times before it lets go. This gives the last stop bit time to settle on the wire before the far end may start to answer.

When automatic mode is off, the pins revert to their ordinary owners. RTS follows either the manual modem-control bit or the hardware flow-control logic. DTR follows its manual bit. The polarity of the automatic level can be flipped, and a select input moves the automatic function from RTS to DTR. Both pins are driven from registers, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While rst is high at a rising edge, rts_o and dtr_o are 0 after that edge.
- R2: With auto_en=1, if tx_busy=1 or txf_empty=0 at an edge, the selected pin shows the enabled level after that edge. The enabled level is 1 when invert_en=0.
- R3: With auto_en=1, in the first edge at which tx_busy=0 and txf_empty=1 after activity, the block loads turn_delay (D) and starts a hold. Ticks are counted only on later edges. The selected pin stays enabled and returns to the idle level after the (D+1)-th such bit_tick edge.
- R4: A turn_delay of 0 releases the driver at the first bit_tick edge after the hold begins.
- R5: If txf_empty falls or tx_busy rises during the hold, the hold is cancelled. The pin stays at the enabled level in every cycle, and a fresh full hold starts when the block next goes idle.
- R6: With invert_en=1, the automatic levels are swapped: the enabled level is 0 and the idle level is 1.
- R7: pin_sel=0 puts the automatic function on rts_o and pin_sel=1 puts it on dtr_o. The pin that is not selected keeps its non-automatic source.
- R8: With auto_en=1, the selected pin ignores mcr_rts, mcr_dtr, flow_en and flow_rts.
- R9: With auto_en=0, rts_o follows flow_rts when flow_en=1 and mcr_rts otherwise, and dtr_o follows mcr_dtr. Each takes the value one edge after it is sampled. Clearing auto_en also abandons any hold.
- R10: A change of turn_delay during a hold does not alter the release of that hold. The value is captured only when the hold begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Enables automatic driver direction control |
| invert_en | input | 1 | Swaps the automatic enabled and idle levels |
| pin_sel | input | 1 | 0: automatic level on RTS, 1: on DTR |
| tx_busy | input | 1 | Transmit shift register is sending a character |
| txf_empty | input | 1 | Transmit FIFO holds no data |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| turn_delay | input | 8 | Turn-around hold in bit times |
| mcr_rts | input | 1 | Manual RTS value |
| mcr_dtr | input | 1 | Manual DTR value |
| flow_en | input | 1 | Hardware flow control owns RTS |
| flow_rts | input | 1 | RTS value requested by flow control |
| rts_o | output | 1 | RTS pin level |
| dtr_o | output | 1 | DTR pin level |

## Verification
A wrong hold counter or state shows at the ports as a driver release that comes one or more bit ticks too early or too late. It can also show as a one-cycle drop of the enabled level when the hold is cancelled. In each case the fault is visible on the selected pin on the edge after the offending tick or input change. A wrong ownership decision shows immediately, one edge after the fact, on either pin. The bench therefore compares both pins against a reference every cycle. It uses long randomized sequences with sparse ticks and varied delays, plus directed holds of 0, 3 and changed delays.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    localparam int unsigned DLY_W_DEF = 8;

    typedef enum logic [1:0] {
        DIR_IDLE   = 2'd0,
        DIR_ACTIVE = 2'd1,
        DIR_HOLD   = 2'd2
    } dir_state_e;

    typedef struct packed {
        logic mcr_rts;
        logic mcr_dtr;
        logic flow_en;
        logic flow_rts;
    } manual_ctl_t;

    function automatic logic auto_level(input logic drive, input logic inv);
        return drive ^ inv;
    endfunction

    function automatic logic rts_owner_level(input manual_ctl_t c);
        return c.flow_en ? c.flow_rts : c.mcr_rts;
    endfunction

endpackage

// File: rtl/rs485_turn_timer.sv
module rs485_turn_timer
    import rs485_dir_pkg::*;
#(
    parameter int unsigned DLY_W = DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             tx_busy,
    input  logic             txf_empty,
    input  logic             bit_tick,
    input  logic [DLY_W-1:0] turn_delay,
    output logic             drive_nxt
);

    localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

    dir_state_e       st_q, st_n;
    logic [DLY_W-1:0] cnt_q, cnt_n;
    logic             tx_pending;

    assign tx_pending = tx_busy || !txf_empty;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (!auto_en) begin
            st_n = DIR_IDLE;
        end else if (tx_pending) begin
            st_n = DIR_ACTIVE;
        end else begin
            case (st_q)
                DIR_ACTIVE: begin
                    st_n  = DIR_HOLD;
                    cnt_n = turn_delay;
                end
                DIR_HOLD: begin
                    if (bit_tick) begin
                        if (cnt_q == '0) begin
                            st_n = DIR_IDLE;
                        end else begin
                            cnt_n = cnt_q - ONE;
                        end
                    end
                end
                default: st_n = DIR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= DIR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign drive_nxt = (st_n != DIR_IDLE);

endmodule

// File: rtl/rs485_pin_mux.sv
module rs485_pin_mux
    import rs485_dir_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        auto_en,
    input  logic        pin_sel,
    input  logic        invert_en,
    input  logic        drive_nxt,
    input  manual_ctl_t ctl,
    output logic        rts_o,
    output logic        dtr_o
);

    logic lvl;
    logic rts_n, dtr_n;

    always_comb begin
        lvl   = auto_level(drive_nxt, invert_en);
        rts_n = (auto_en && !pin_sel) ? lvl : rts_owner_level(ctl);
        dtr_n = (auto_en &&  pin_sel) ? lvl : ctl.mcr_dtr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rts_o <= 1'b0;
            dtr_o <= 1'b0;
        end else begin
            rts_o <= rts_n;
            dtr_o <= dtr_n;
        end
    end

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int unsigned DLY_W = DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             invert_en,
    input  logic             pin_sel,
    input  logic             tx_busy,
    input  logic             txf_empty,
    input  logic             bit_tick,
    input  logic [DLY_W-1:0] turn_delay,
    input  logic             mcr_rts,
    input  logic             mcr_dtr,
    input  logic             flow_en,
    input  logic             flow_rts,
    output logic             rts_o,
    output logic             dtr_o
);

    logic        drive_nxt;
    manual_ctl_t ctl;

    assign ctl = '{mcr_rts: mcr_rts, mcr_dtr: mcr_dtr,
                   flow_en: flow_en, flow_rts: flow_rts};

    rs485_turn_timer #(.DLY_W(DLY_W)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .auto_en    (auto_en),
        .tx_busy    (tx_busy),
        .txf_empty  (txf_empty),
        .bit_tick   (bit_tick),
        .turn_delay (turn_delay),
        .drive_nxt  (drive_nxt)
    );

    rs485_pin_mux mux_i (
        .clk       (clk),
        .rst       (rst),
        .auto_en   (auto_en),
        .pin_sel   (pin_sel),
        .invert_en (invert_en),
        .drive_nxt (drive_nxt),
        .ctl       (ctl),
        .rts_o     (rts_o),
        .dtr_o     (dtr_o)
    );

endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic auto_en,
    input logic invert_en,
    input logic pin_sel,
    input logic tx_busy,
    input logic txf_empty,
    input logic mcr_rts,
    input logic mcr_dtr,
    input logic flow_en,
    input logic flow_rts,
    input logic rts_o,
    input logic dtr_o
);

    // R1: reset forces both pins low
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> (!rts_o && !dtr_o));

    // R2, R6, R7: pending data enables the selected pin
    a_r2_rts_enabled: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !pin_sel && (tx_busy || !txf_empty)) |=> (rts_o != $past(invert_en)));

    a_r2_dtr_enabled: assert property (@(posedge clk) disable iff (rst)
        (auto_en && pin_sel && (tx_busy || !txf_empty)) |=> (dtr_o != $past(invert_en)));

    // R9: manual and flow ownership of RTS without automatic mode
    a_r9_rts_manual: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && !flow_en) |=> (rts_o == $past(mcr_rts)));

    a_r9_rts_flow: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && flow_en) |=> (rts_o == $past(flow_rts)));

    // R7: unselected DTR keeps its manual source
    a_r7_dtr_manual: assert property (@(posedge clk) disable iff (rst)
        !(auto_en && pin_sel) |=> (dtr_o == $past(mcr_dtr)));

endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .auto_en   (auto_en),
    .invert_en (invert_en),
    .pin_sel   (pin_sel),
    .tx_busy   (tx_busy),
    .txf_empty (txf_empty),
    .mcr_rts   (mcr_rts),
    .mcr_dtr   (mcr_dtr),
    .flow_en   (flow_en),
    .flow_rts  (flow_rts),
    .rts_o     (rts_o),
    .dtr_o     (dtr_o)
);

// File: tb/rs485_dir_ctrl_tb_top.sv
module rs485_dir_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_en = 0, invert_en = 0, pin_sel = 0;
    logic       tx_busy = 0, txf_empty = 1, bit_tick = 0;
    logic [7:0] turn_delay = 8'd0;
    logic       mcr_rts = 0, mcr_dtr = 0, flow_en = 0, flow_rts = 0;
    logic       rts_o, dtr_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // reference state, written from the requirements
    bit m_on   = 0;
    bit m_hold = 0;
    int m_left = 0;
    bit e_rts  = 0;
    bit e_dtr  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs485_dir_ctrl dut_i (
        .clk(clk), .rst(rst), .auto_en(auto_en), .invert_en(invert_en),
        .pin_sel(pin_sel), .tx_busy(tx_busy), .txf_empty(txf_empty),
        .bit_tick(bit_tick), .turn_delay(turn_delay), .mcr_rts(mcr_rts),
        .mcr_dtr(mcr_dtr), .flow_en(flow_en), .flow_rts(flow_rts),
        .rts_o(rts_o), .dtr_o(dtr_o)
    );

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
            report();
        end
    end

    function automatic bit auto_pin(input bit on, input bit inv);
        return on ? !inv : inv;
    endfunction

    task automatic model_edge;
        if (rst) begin
            m_on = 0; m_hold = 0; m_left = 0;
            e_rts = 0; e_dtr = 0;
            return;
        end
        if (!auto_en) begin
            m_on = 0; m_hold = 0;
        end else if (tx_busy || !txf_empty) begin
            m_on = 1; m_hold = 0;
        end else if (m_on && !m_hold) begin
            m_hold = 1; m_left = turn_delay;
        end else if (m_hold && bit_tick) begin
            if (m_left == 0) begin m_on = 0; m_hold = 0; end
            else m_left--;
        end
        e_rts = (auto_en && !pin_sel) ? auto_pin(m_on, invert_en)
                                      : (flow_en ? flow_rts : mcr_rts);
        e_dtr = (auto_en && pin_sel) ? auto_pin(m_on, invert_en) : mcr_dtr;
    endtask

    // inputs are set between edges; one edge is applied, then outputs compared
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_checks++;
        if (rts_o !== e_rts || dtr_o !== e_dtr) begin
            n_fail++;
            $display("FAIL %s: actual rts=%b dtr=%b, expected rts=%b dtr=%b",
                     tag, rts_o, dtr_o, e_rts, e_dtr);
        end
    endtask

    task automatic tick_step(input string tag);
        bit_tick = 1; step(tag); bit_tick = 0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0485));
        @(negedge clk);
        mcr_rts = 1; mcr_dtr = 1;
        step("R1"); step("R1");
        rst = 0;

        // R9: manual and flow ownership
        step("R9");
        flow_en = 1; flow_rts = 0; step("R9");
        flow_rts = 1; mcr_rts = 0; step("R9");

        // R8: automatic mode overrides manual and flow sources
        auto_en = 1; flow_rts = 1; mcr_rts = 1; step("R8");

        // R2 then R3 with a delay of 3
        turn_delay = 8'd3;
        txf_empty = 0; step("R2");
        txf_empty = 1; tx_busy = 1; step("R2");
        tx_busy = 0; step("R3");
        for (int i = 0; i < 4; i++) begin
            step("R3"); tick_step("R3");
        end
        step("R3");

        // R4: zero delay
        turn_delay = 8'd0;
        tx_busy = 1; step("R2"); tx_busy = 0; step("R4");
        step("R4"); tick_step("R4"); step("R4");

        // R5: cancellation during hold
        turn_delay = 8'd2;
        tx_busy = 1; step("R5"); tx_busy = 0; step("R5");
        tick_step("R5"); tick_step("R5");
        txf_empty = 0; tick_step("R5"); txf_empty = 1; step("R5");
        for (int i = 0; i < 4; i++) tick_step("R5");

        // R10: delay change during a hold is ignored
        turn_delay = 8'd1;
        tx_busy = 1; step("R10"); tx_busy = 0; step("R10");
        turn_delay = 8'd9;
        tick_step("R10"); tick_step("R10"); step("R10");

        // R6: inverted levels
        invert_en = 1; step("R6");
        tx_busy = 1; step("R6"); tx_busy = 0; step("R6"); tick_step("R6");
        for (int i = 0; i < 10; i++) tick_step("R6");

        // R7: automatic function on DTR
        invert_en = 0; pin_sel = 1; mcr_dtr = 1; mcr_rts = 0; flow_en = 0;
        step("R7");
        txf_empty = 0; step("R7"); txf_empty = 1; turn_delay = 8'd0;
        step("R7"); tick_step("R7"); step("R7");

        // R9: leaving automatic mode abandons a hold
        pin_sel = 0; turn_delay = 8'd5;
        tx_busy = 1; step("R9"); tx_busy = 0; step("R9");
        auto_en = 0; step("R9"); auto_en = 1; step("R9");

        // randomized mixture
        for (int i = 0; i < 6000; i++) begin
            rst        = ($urandom_range(0, 499) == 0);
            if ($urandom_range(0, 99) == 0) auto_en = $urandom_range(0, 1);
            if ($urandom_range(0, 199) == 0) invert_en = $urandom_range(0, 1);
            if ($urandom_range(0, 199) == 0) pin_sel = $urandom_range(0, 1);
            tx_busy    = ($urandom_range(0, 9) < 3);
            txf_empty  = ($urandom_range(0, 9) < 8);
            bit_tick   = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 31) == 0) turn_delay = 8'($urandom_range(0, 6));
            mcr_rts    = $urandom_range(0, 1);
            mcr_dtr    = $urandom_range(0, 1);
            flow_en    = $urandom_range(0, 1);
            flow_rts   = $urandom_range(0, 1);
            if (rst) step("R1");
            else if (!auto_en) step("R9");
            else step("R3");
        end
        rst = 0; bit_tick = 0;
        report();
    end

endmodule